// File: doc/BRIEF.md
# Interrupt versus Reset Event Router

The router watches a set of system event inputs (watchdog overflow, temperature warning, ground shift, SPI frame-length error, battery sense, secondary-supply short, CAN and LIN failure status, the wake pin, and CAN and LIN bus wake) and sorts each detected event into one of three outcomes. It either latches a pending interrupt flag, requests a system reset, or drops the event. The outcome depends on the interrupt-enable bit of the source and on the current operating mode. For some sources a cleared enable bit masks the event. For others it turns the event into a reset.

Level inputs pass through registered edge or change detectors. Single-cycle strobe inputs count as an event in each cycle they are high. Software acknowledges a pending flag by pulsing its clear bit. A reset request appears as a one-cycle pulse, and the same pulse wipes every pending flag.

Top module: `evt_router`

## Requirements
- R1: While reset is held and in the first cycle after it, `pending_o` is 0, `irq_n_o` is 1 and `rst_req_o` is 0. Detector history resets to the idle levels: battery sense and wake pin high, all other levels low.
- R2: Pending bit positions are fixed: 0 watchdog, 1 temperature, 2 ground shift, 3 SPI length error, 4 battery sense, 5 supply short, 6 CAN failure, 7 LIN failure, 8 wake pin, 9 CAN bus wake, 10 LIN bus wake. `irq_en_i` and `clr_i` use the same positions. Mode codes are 0 start-up, 1 restart, 2 normal, 3 flash, 4 standby, 5 sleep. An event seen at a clock edge shows on the outputs after that edge.
- R3: A change of the temperature-warning level or the ground-shift level in either direction sets its pending bit when that bit is enabled. Otherwise the change is ignored.
- R4: A falling edge on battery sense, or a rising edge on supply short, sets its pending bit when enabled. Otherwise it is ignored. The opposite edges are always ignored.
- R5: Any change in value of the CAN failure status or the LIN failure status sets its pending bit when enabled. Otherwise it is ignored.
- R6: An SPI length error with its enable at 0 is ignored in every mode. With the enable at 1, it requests a reset in start-up or restart mode and sets its pending bit in any other mode.
- R7: A watchdog overflow sets its pending bit only in standby mode with its enable at 1. In every other case it requests a reset.
- R8: A wake-pin falling edge sets its pending bit in normal, flash or standby mode when enabled. It requests a reset in standby mode when not enabled. Every other case is ignored, and rising edges are ignored.
- R9: A CAN or LIN bus wake strobe sets its pending bit when enabled and requests a reset when not enabled, in any mode.
- R10: A reset request is a one-cycle pulse on `rst_req_o`. `pending_o` reads 0 in that same cycle, and interrupt events detected alongside the causing event are dropped.
- R11: `irq_n_o` is low exactly when some pending bit is set.
- R12: A pending bit stays set until a clear strobe for that bit. A new event on a bit wins over a clear strobe for that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode code |
| irq_en_i | input | 11 | Per-source interrupt enable |
| clr_i | input | 11 | Per-source pending clear strobe |
| wdog_ovf_i | input | 1 | Watchdog overflow strobe |
| temp_warn_i | input | 1 | Temperature-warning level |
| gnd_shift_i | input | 1 | Ground-shift level |
| spi_len_err_i | input | 1 | SPI frame-length error strobe |
| bat_sense_i | input | 1 | Battery sense level |
| sup_short_i | input | 1 | Secondary supply short level |
| can_fail_i | input | 3 | CAN failure status |
| lin_fail_i | input | 2 | LIN failure status |
| wake_pin_i | input | 1 | Wake pin level |
| can_wake_i | input | 1 | CAN bus wake strobe |
| lin_wake_i | input | 1 | LIN bus wake strobe |
| pending_o | output | 11 | Latched pending interrupt flags |
| irq_n_o | output | 1 | Active-low interrupt line |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest cases are those where the mode and the enable together turn a source from interrupt into reset. Examples are a wake-pin edge in standby with its enable cleared, next to the same edge in flash or sleep, and an SPI error in restart with the enable cleared. The stimulus first leaves other flags pending and then walks the mode input through each code before firing the source, so a reset is seen both as a pulse and as the wipe of those earlier flags. Set and clear for the same bit in the same cycle is also driven on purpose.

// File: rtl/evt_router_pkg.sv
// Package: shared source indices, mode codes and action types for the
// event router. Assumes a fixed set of eleven event sources.
package evt_router_pkg;
    localparam int NSRC = 11;

    localparam int SRC_WDOG  = 0;
    localparam int SRC_TEMP  = 1;
    localparam int SRC_GND   = 2;
    localparam int SRC_SPI   = 3;
    localparam int SRC_BAT   = 4;
    localparam int SRC_SUP   = 5;
    localparam int SRC_CANF  = 6;
    localparam int SRC_LINF  = 7;
    localparam int SRC_WAKE  = 8;
    localparam int SRC_CANW  = 9;
    localparam int SRC_LINW  = 10;

    localparam int EDGE_CHANGE = 0;
    localparam int EDGE_RISE   = 1;
    localparam int EDGE_FALL   = 2;

    typedef enum logic [2:0] {
        MODE_STARTUP = 3'd0,
        MODE_RESTART = 3'd1,
        MODE_NORMAL  = 3'd2,
        MODE_FLASH   = 3'd3,
        MODE_STANDBY = 3'd4,
        MODE_SLEEP   = 3'd5
    } op_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_RESET = 2'd2
    } evt_action_e;
endpackage

// File: rtl/evt_edge.sv
// Module: registered edge/change detector for one level input.
// KIND picks change, rising or falling detection; rising/falling use bit 0.
// Assumes the input is already synchronous to clk. History resets to IDLE.
module evt_edge #(
    parameter int          W    = 1,
    parameter int          KIND = 0,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic         hit
);
    import evt_router_pkg::*;

    logic [W-1:0] prev_q;

    // Hold the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= din;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign hit = din[0] & ~prev_q[0];
        end else if (KIND == EDGE_FALL) begin : g_fall
            assign hit = ~din[0] & prev_q[0];
        end else begin : g_change
            assign hit = |(din ^ prev_q);
        end
    endgenerate
endmodule

// File: rtl/evt_classify.sv
// Module: combinational routing of detected events to interrupt, reset or
// nothing, by source, enable bit and operating mode. Undefined mode codes
// act like sleep.
module evt_classify (
    input  logic [evt_router_pkg::NSRC-1:0] hit,
    input  logic [evt_router_pkg::NSRC-1:0] en,
    input  evt_router_pkg::op_mode_e        mode,
    output logic [evt_router_pkg::NSRC-1:0] irq_set,
    output logic                            rst_cause
);
    import evt_router_pkg::*;

    // Decide the action for one source given its enable and the mode.
    function automatic evt_action_e route(input int idx, input logic ena,
                                          input op_mode_e m);
        evt_action_e a;
        a = ACT_NONE;
        case (idx)
            SRC_WDOG: a = (m == MODE_STANDBY && ena) ? ACT_IRQ : ACT_RESET;
            SRC_SPI: begin
                if (!ena)                                      a = ACT_NONE;
                else if (m == MODE_STARTUP || m == MODE_RESTART) a = ACT_RESET;
                else                                           a = ACT_IRQ;
            end
            SRC_WAKE: begin
                if (ena && (m == MODE_NORMAL || m == MODE_FLASH ||
                            m == MODE_STANDBY))                a = ACT_IRQ;
                else if (!ena && m == MODE_STANDBY)            a = ACT_RESET;
                else                                           a = ACT_NONE;
            end
            SRC_CANW, SRC_LINW: a = ena ? ACT_IRQ : ACT_RESET;
            default: a = ena ? ACT_IRQ : ACT_NONE;
        endcase
        return a;
    endfunction

    logic [NSRC-1:0] rst_vec;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            evt_action_e act;
            // Action of source i this cycle, none when no event.
            always_comb act = hit[i] ? route(i, en[i], mode) : ACT_NONE;
            assign irq_set[i] = (act == ACT_IRQ);
            assign rst_vec[i] = (act == ACT_RESET);
        end
    endgenerate

    assign rst_cause = |rst_vec;
endmodule

// File: rtl/evt_pend.sv
// Module: pending flag bank and reset pulse register. A reset cause clears
// every flag and raises the pulse for one cycle; otherwise set beats clear.
module evt_pend #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_set,
    input  logic [N-1:0] clr,
    input  logic         rst_cause,
    output logic [N-1:0] pending,
    output logic         rst_req
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // Latch one flag: reset wipes, set wins, clear drops.
            always_ff @(posedge clk) begin
                if (!rst_n)          pending[i] <= 1'b0;
                else if (rst_cause)  pending[i] <= 1'b0;
                else if (irq_set[i]) pending[i] <= 1'b1;
                else if (clr[i])     pending[i] <= 1'b0;
            end
        end
    endgenerate

    // Register the reset request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= rst_cause;
    end
endmodule

// File: rtl/evt_router.sv
// Module: top of the interrupt versus reset event router. Detects edges and
// changes on level inputs, routes every event by enable and mode, and keeps
// pending flags. Assumes all inputs are synchronous to clk.
module evt_router #(
    parameter int CAN_FAIL_W = 3,
    parameter int LIN_FAIL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            mode_i,
    input  logic [10:0]           irq_en_i,
    input  logic [10:0]           clr_i,
    input  logic                  wdog_ovf_i,
    input  logic                  temp_warn_i,
    input  logic                  gnd_shift_i,
    input  logic                  spi_len_err_i,
    input  logic                  bat_sense_i,
    input  logic                  sup_short_i,
    input  logic [CAN_FAIL_W-1:0] can_fail_i,
    input  logic [LIN_FAIL_W-1:0] lin_fail_i,
    input  logic                  wake_pin_i,
    input  logic                  can_wake_i,
    input  logic                  lin_wake_i,
    output logic [10:0]           pending_o,
    output logic                  irq_n_o,
    output logic                  rst_req_o
);
    import evt_router_pkg::*;

    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] irq_set;
    logic            rst_cause;

    evt_edge #(.W(1), .KIND(EDGE_CHANGE), .IDLE(1'b0)) u_temp (
        .clk(clk), .rst_n(rst_n), .din(temp_warn_i), .hit(hit[SRC_TEMP]));
    evt_edge #(.W(1), .KIND(EDGE_CHANGE), .IDLE(1'b0)) u_gnd (
        .clk(clk), .rst_n(rst_n), .din(gnd_shift_i), .hit(hit[SRC_GND]));
    evt_edge #(.W(1), .KIND(EDGE_FALL), .IDLE(1'b1)) u_bat (
        .clk(clk), .rst_n(rst_n), .din(bat_sense_i), .hit(hit[SRC_BAT]));
    evt_edge #(.W(1), .KIND(EDGE_RISE), .IDLE(1'b0)) u_sup (
        .clk(clk), .rst_n(rst_n), .din(sup_short_i), .hit(hit[SRC_SUP]));
    evt_edge #(.W(CAN_FAIL_W), .KIND(EDGE_CHANGE), .IDLE('0)) u_canf (
        .clk(clk), .rst_n(rst_n), .din(can_fail_i), .hit(hit[SRC_CANF]));
    evt_edge #(.W(LIN_FAIL_W), .KIND(EDGE_CHANGE), .IDLE('0)) u_linf (
        .clk(clk), .rst_n(rst_n), .din(lin_fail_i), .hit(hit[SRC_LINF]));
    evt_edge #(.W(1), .KIND(EDGE_FALL), .IDLE(1'b1)) u_wake (
        .clk(clk), .rst_n(rst_n), .din(wake_pin_i), .hit(hit[SRC_WAKE]));

    // Strobe sources count as an event every cycle they are high.
    assign hit[SRC_WDOG] = wdog_ovf_i;
    assign hit[SRC_SPI]  = spi_len_err_i;
    assign hit[SRC_CANW] = can_wake_i;
    assign hit[SRC_LINW] = lin_wake_i;

    evt_classify u_cls (
        .hit      (hit),
        .en       (irq_en_i),
        .mode     (op_mode_e'(mode_i)),
        .irq_set  (irq_set),
        .rst_cause(rst_cause)
    );

    evt_pend #(.N(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_set  (irq_set),
        .clr      (clr_i),
        .rst_cause(rst_cause),
        .pending  (pending_o),
        .rst_req  (rst_req_o)
    );

    assign irq_n_o = ~|pending_o;
endmodule

// File: rtl/evt_router_chk.sv
// Checker: temporal properties of the event router, bound to its top.
module evt_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode_i,
    input logic [10:0] irq_en_i,
    input logic [10:0] clr_i,
    input logic        wdog_ovf_i,
    input logic        spi_len_err_i,
    input logic        can_wake_i,
    input logic [10:0] pending_o,
    input logic        rst_req_o
);
    import evt_router_pkg::*;

    assert_reset_wipes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (pending_o == '0));

    assert_spi_boot_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_len_err_i && irq_en_i[SRC_SPI] && (mode_i == 3'd0 || mode_i == 3'd1))
        |=> rst_req_o);

    assert_wdog_masked_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_ovf_i && !irq_en_i[SRC_WDOG]) |=> rst_req_o);

    assert_canwake_masked_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (can_wake_i && !irq_en_i[SRC_CANW]) |=> rst_req_o);

    assert_sticky_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_o |-> ((($past(pending_o) & ~pending_o) & ~$past(clr_i)) == '0));
endmodule

bind evt_router evt_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .irq_en_i     (irq_en_i),
    .clr_i        (clr_i),
    .wdog_ovf_i   (wdog_ovf_i),
    .spi_len_err_i(spi_len_err_i),
    .can_wake_i   (can_wake_i),
    .pending_o    (pending_o),
    .rst_req_o    (rst_req_o)
);

// File: tb/sim_evt_router.sv
// Scoreboard bench: stimulus steps push expected outputs, a monitor pops them.
module sim_evt_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd2;
    logic [10:0] irq_en_i = '1;
    logic [10:0] clr_i = '0;
    logic        wdog_ovf_i = 0, temp_warn_i = 0, gnd_shift_i = 0, spi_len_err_i = 0;
    logic        bat_sense_i = 1, sup_short_i = 0, wake_pin_i = 1;
    logic        can_wake_i = 0, lin_wake_i = 0;
    logic [2:0]  can_fail_i = '0;
    logic [1:0]  lin_fail_i = '0;
    logic [10:0] pending_o;
    logic        irq_n_o, rst_req_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    evt_router u0 (.*);

    // Push one expected result, let one clock pass, drop strobes.
    task automatic chk(input logic [10:0] ep, input logic er, input string tag);
        exp_q.push_back({er, ep});
        tag_q.push_back(tag);
        @(negedge clk);
        wdog_ovf_i = 0; spi_len_err_i = 0; can_wake_i = 0; lin_wake_i = 0;
        clr_i = '0;
    endtask

    // Monitor: compare outputs after each rising edge with the queued item.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            logic [11:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pending_o !== e[10:0] || rst_req_o !== e[11] ||
                irq_n_o !== (e[10:0] == '0)) begin
                fails++;
                $display("FAIL %s (R11 irq_n): pend=%h rst=%b irq_n=%b exp pend=%h rst=%b irq_n=%b",
                         t, pending_o, rst_req_o, irq_n_o, e[10:0], e[11], (e[10:0] == '0));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk(11'h000, 0, "R1 during reset");
        rst_n = 1;
        chk(11'h000, 0, "R1 after reset");
        temp_warn_i = 1;          chk(11'h002, 0, "R3 temp rise");
        temp_warn_i = 0;          chk(11'h002, 0, "R3 temp fall");
        clr_i = 11'h002;          chk(11'h000, 0, "R12 clear");
        irq_en_i[1] = 0; temp_warn_i = 1; chk(11'h000, 0, "R3 masked");
        irq_en_i = '1; gnd_shift_i = 1;   chk(11'h004, 0, "R3 ground");
        bat_sense_i = 0;          chk(11'h014, 0, "R4 battery fall");
        bat_sense_i = 1;          chk(11'h014, 0, "R4 battery rise ignored");
        sup_short_i = 1;          chk(11'h034, 0, "R4 supply short");
        can_fail_i = 3'b010;      chk(11'h074, 0, "R5 can status");
        lin_fail_i = 2'b01;       chk(11'h0F4, 0, "R5 lin status");
        spi_len_err_i = 1;        chk(11'h0FC, 0, "R6 normal irq");
        spi_len_err_i = 1; clr_i = 11'h008; chk(11'h0FC, 0, "R12 set beats clear");
        clr_i = '1;               chk(11'h000, 0, "R12 clear all");
        irq_en_i[3] = 0; spi_len_err_i = 1; chk(11'h000, 0, "R6 masked normal");
        irq_en_i = '1; gnd_shift_i = 0;     chk(11'h004, 0, "R2 ground fall");
        mode_i = 3'd0; spi_len_err_i = 1;   chk(11'h000, 1, "R6 R10 startup reset");
        chk(11'h000, 0, "R10 single pulse");
        mode_i = 3'd1; irq_en_i[3] = 0; spi_len_err_i = 1; chk(11'h000, 0, "R6 restart masked");
        irq_en_i = '1; mode_i = 3'd2; wdog_ovf_i = 1; chk(11'h000, 1, "R7 normal reset");
        mode_i = 3'd4; wdog_ovf_i = 1;      chk(11'h001, 0, "R7 standby irq");
        irq_en_i[0] = 0; wdog_ovf_i = 1;    chk(11'h000, 1, "R7 standby masked reset");
        irq_en_i = '1; mode_i = 3'd2; wake_pin_i = 0; chk(11'h100, 0, "R8 normal irq");
        wake_pin_i = 1;                     chk(11'h100, 0, "R8 rise ignored");
        clr_i = 11'h100; mode_i = 3'd5; wake_pin_i = 0; chk(11'h000, 0, "R8 sleep ignored");
        wake_pin_i = 1; mode_i = 3'd4; irq_en_i[8] = 0; chk(11'h000, 0, "R8 setup");
        wake_pin_i = 0;                     chk(11'h000, 1, "R8 standby masked reset");
        wake_pin_i = 1; mode_i = 3'd3;      chk(11'h000, 0, "R8 setup flash");
        wake_pin_i = 0;                     chk(11'h000, 0, "R8 flash masked ignored");
        irq_en_i = '1; wake_pin_i = 1; mode_i = 3'd2; can_wake_i = 1; chk(11'h200, 0, "R9 can irq");
        irq_en_i[10] = 0; lin_wake_i = 1;   chk(11'h000, 1, "R9 lin reset");
        irq_en_i = '1; lin_wake_i = 1;      chk(11'h400, 0, "R9 lin irq");
        irq_en_i[9] = 0; mode_i = 3'd5; can_wake_i = 1; chk(11'h000, 1, "R9 can reset");
        irq_en_i = '1; mode_i = 3'd2; sup_short_i = 0;  chk(11'h000, 0, "R4 supply fall ignored");
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule